// File: doc/BRIEF.md
# Port Select and Status Indicator Controller

This block turns the configuration straps of a 10 Mb/s twisted-pair/AUI serial adapter into internal enables. Two select straps choose the TP port, the AUI port, or automatic selection. A link-enable strap gates link-pulse handling. Two shared straps change meaning with the chosen port and the link-enable state: they drive SQE test, loopback, jabber and auto-duplex enables. One otherwise unused strap combination forces full duplex and keeps link pulses running.

The block also drives four active-low, open-drain-style indicators, where 1 means released and 0 means driven low:
- Activity: stretched after any transmit or receive activity.
- Port: blinks while reversed receive polarity is seen on the TP port.
- Link: low while a link is detected.
- Full duplex: low while full duplex is forced.

All timing comes from a prescaled counter on the master clock. Link-pulse generation and detection are not part of this block, nor is any analog receiving.

Top module: `strap_port_ctrl`

## Requirements
- R1: The select straps {force_aui_i, force_tp_i} decode as follows: 01 forces TP (port_tp_o=1), 10 forces AUI (port_tp_o=0), and the invalid value 11 is treated as AUI.
- R2: With the select straps at 00 and link_en_i=1, the port follows link_det_i one clock later: TP while a link was seen at the previous edge, AUI otherwise.
- R3: With link_en_i=0 and full duplex not forced, link_pulse_tx_en_o=0, link_det_i has no effect (led_link_n_o=1), and straps 00 choose AUI.
- R4: Full duplex is forced when the select straps are 00, link_en_i=0 and strap_a_i=1. In that state:
  - full_dplx_o=1 and port_tp_o=1;
  - link_pulse_tx_en_o=1;
  - link_det_i is honoured;
  - led_fdx_n_o=0.
- R5: strap_a_i has a meaning that depends on the port and on link_en_i:
  - TP with link_en_i=1: sqe_test_en_o equals strap_a_i.
  - AUI with link_en_i=0: loopback_en_o equals the inverse of strap_a_i.
  - Any other case: both outputs are 0.
- R6: strap_b_i has a meaning that depends on the port and on link_en_i:
  - TP with link_en_i=1: auto_dplx_en_o equals the inverse of strap_b_i.
  - AUI with link_en_i=0: jabber_en_o equals strap_b_i.
  - Any other case: jabber_en_o=1 and auto_dplx_en_o=0.
- R7: led_act_n_o goes low in the clock after any cycle with tx_act_i or rx_act_i high. It stays low for exactly STRETCH_TICKS*TICK_DIV cycles after the last such cycle, and each new activity restarts the window.
- R8: led_port_n_o is 1 for AUI and 0 for TP. While pol_rev_i=1 on TP it toggles, starting low, with a half period of BLINK_TICKS*TICK_DIV cycles.
- R9: led_link_n_o is 0 exactly while link_det_i=1 and link functions are on (link_en_i=1 or full duplex forced). led_fdx_n_o is 0 exactly while full duplex is forced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| force_aui_i | input | 1 | Select strap, AUI side |
| force_tp_i | input | 1 | Select strap, TP side |
| link_en_i | input | 1 | Link functions enable strap (0 disables) |
| strap_a_i | input | 1 | Shared strap A (SQE test / loopback / full duplex) |
| strap_b_i | input | 1 | Shared strap B (auto-duplex / jabber) |
| link_det_i | input | 1 | Link pulses detected on TP input |
| pol_rev_i | input | 1 | Reversed TP receive polarity detected |
| tx_act_i | input | 1 | Transmit activity |
| rx_act_i | input | 1 | Receive activity |
| port_tp_o | output | 1 | 1 = TP port selected, 0 = AUI |
| sqe_test_en_o | output | 1 | SQE test enable |
| loopback_en_o | output | 1 | Loopback enable |
| jabber_en_o | output | 1 | Jabber function enable |
| auto_dplx_en_o | output | 1 | Auto-duplex enable |
| full_dplx_o | output | 1 | Full duplex forced |
| link_pulse_tx_en_o | output | 1 | Link pulse transmit enable |
| led_port_n_o | output | 1 | Port indicator, 1 = released |
| led_act_n_o | output | 1 | Activity indicator, 1 = released |
| led_link_n_o | output | 1 | Link indicator, 1 = released |
| led_fdx_n_o | output | 1 | Full duplex indicator, 1 = released |

## Verification
The bench aims at the shared straps in every port and link-enable context, since they are the easiest place to go wrong. A decoder that ignored the context would raise SQE test on AUI, or enable loopback on TP. It also drives the invalid select value and the full-duplex combination. A design that mishandled these would leave link pulses off, pick AUI, or treat code 11 as TP.

The registered auto-select is probed just before a clock edge, which exposes a combinational path or an extra stage. The activity window is measured to the exact cycle, both once and after a restart in mid-window; an off-by-one prescaler or a reload that is missing would show up there. The blink half period is measured between successive toggles.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {
    SEL_AUTO = 2'b00,
    SEL_TP   = 2'b01,
    SEL_AUI  = 2'b10,
    SEL_BAD  = 2'b11
  } sel_e;

  typedef struct packed {
    logic port_tp;
    logic sqe_en;
    logic lpbk_en;
    logic jab_en;
    logic adplx_en;
    logic fdx;
    logic link_on;
  } port_cfg_t;
endpackage

// File: rtl/sp_prescaler.sv
module sp_prescaler #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick_o = ~clr_i;
    end else begin : g_cnt
      localparam int unsigned W = $clog2(DIV);
      localparam logic [W-1:0] LAST = W'(DIV - 1);
      logic [W-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)               cnt_q <= '0;
        else if (clr_i)            cnt_q <= '0;
        else if (cnt_q == LAST)    cnt_q <= '0;
        else                       cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = ~clr_i & (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/sp_strap_decode.sv
module sp_strap_decode
  import sp_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      force_aui_i,
  input  logic      force_tp_i,
  input  logic      link_en_i,
  input  logic      strap_a_i,
  input  logic      strap_b_i,
  input  logic      link_det_i,
  output port_cfg_t cfg_o
);
  sel_e sel;
  logic fdx_force;
  logic auto_tp_q;
  logic tp;
  logic tp_lnk;
  logic aui_nolnk;

  assign sel       = sel_e'({force_aui_i, force_tp_i});
  assign fdx_force = (sel == SEL_AUTO) & ~link_en_i & strap_a_i;

  // automatic choice sampled on the master clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) auto_tp_q <= 1'b0;
    else         auto_tp_q <= link_det_i & link_en_i;
  end

  always_comb begin
    unique case (sel)
      SEL_TP:   tp = 1'b1;
      SEL_AUTO: tp = link_en_i ? auto_tp_q : fdx_force;
      default:  tp = 1'b0;
    endcase
  end

  assign tp_lnk    = tp & link_en_i;
  assign aui_nolnk = ~tp & ~link_en_i;

  always_comb begin
    cfg_o.port_tp  = tp;
    cfg_o.sqe_en   = tp_lnk & strap_a_i;
    cfg_o.lpbk_en  = aui_nolnk & ~strap_a_i;
    cfg_o.adplx_en = tp_lnk & ~strap_b_i;
    cfg_o.jab_en   = aui_nolnk ? strap_b_i : 1'b1;
    cfg_o.fdx      = fdx_force;
    cfg_o.link_on  = link_en_i | fdx_force;
  end
endmodule

// File: rtl/sp_act_stretch.sv
module sp_act_stretch #(
  parameter int unsigned TICK_DIV      = 4,
  parameter int unsigned STRETCH_TICKS = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  output logic on_o
);
  localparam int unsigned CW = $clog2(STRETCH_TICKS + 1);
  localparam logic [CW-1:0] LOAD = CW'(STRETCH_TICKS);

  logic tick;
  logic [CW-1:0] left_q;

  // prescaler restarts with every activity so the window is exact
  sp_prescaler #(.DIV(TICK_DIV)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (act_i),
    .tick_o (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    left_q <= '0;
    else if (act_i)                 left_q <= LOAD;
    else if (tick && left_q != '0)  left_q <= left_q - 1'b1;
  end

  assign on_o = (left_q != '0);
endmodule

// File: rtl/sp_pol_blink.sv
module sp_pol_blink #(
  parameter int unsigned TICK_DIV    = 4,
  parameter int unsigned BLINK_TICKS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic phase_o
);
  localparam int unsigned BW = (BLINK_TICKS > 1) ? $clog2(BLINK_TICKS) : 1;
  localparam logic [BW-1:0] LAST = BW'(BLINK_TICKS - 1);

  logic tick;
  logic [BW-1:0] tcnt_q;
  logic phase_q;

  sp_prescaler #(.DIV(TICK_DIV)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (~en_i),
    .tick_o (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tcnt_q  <= '0;
      phase_q <= 1'b0;
    end else if (!en_i) begin
      tcnt_q  <= '0;
      phase_q <= 1'b0;
    end else if (tick) begin
      if (tcnt_q == LAST) begin
        tcnt_q  <= '0;
        phase_q <= ~phase_q;
      end else begin
        tcnt_q  <= tcnt_q + 1'b1;
      end
    end
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/strap_port_ctrl.sv
module strap_port_ctrl
  import sp_pkg::*;
#(
  parameter int unsigned TICK_DIV      = 50000,
  parameter int unsigned STRETCH_TICKS = 200,
  parameter int unsigned BLINK_TICKS   = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic force_aui_i,
  input  logic force_tp_i,
  input  logic link_en_i,
  input  logic strap_a_i,
  input  logic strap_b_i,
  input  logic link_det_i,
  input  logic pol_rev_i,
  input  logic tx_act_i,
  input  logic rx_act_i,
  output logic port_tp_o,
  output logic sqe_test_en_o,
  output logic loopback_en_o,
  output logic jabber_en_o,
  output logic auto_dplx_en_o,
  output logic full_dplx_o,
  output logic link_pulse_tx_en_o,
  output logic led_port_n_o,
  output logic led_act_n_o,
  output logic led_link_n_o,
  output logic led_fdx_n_o
);
  port_cfg_t cfg;
  logic act_on;
  logic blink_phase;

  sp_strap_decode u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .force_aui_i (force_aui_i),
    .force_tp_i  (force_tp_i),
    .link_en_i   (link_en_i),
    .strap_a_i   (strap_a_i),
    .strap_b_i   (strap_b_i),
    .link_det_i  (link_det_i),
    .cfg_o       (cfg)
  );

  sp_act_stretch #(
    .TICK_DIV      (TICK_DIV),
    .STRETCH_TICKS (STRETCH_TICKS)
  ) u_act (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (tx_act_i | rx_act_i),
    .on_o   (act_on)
  );

  sp_pol_blink #(
    .TICK_DIV    (TICK_DIV),
    .BLINK_TICKS (BLINK_TICKS)
  ) u_blink (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (pol_rev_i & cfg.port_tp),
    .phase_o (blink_phase)
  );

  assign port_tp_o          = cfg.port_tp;
  assign sqe_test_en_o      = cfg.sqe_en;
  assign loopback_en_o      = cfg.lpbk_en;
  assign jabber_en_o        = cfg.jab_en;
  assign auto_dplx_en_o     = cfg.adplx_en;
  assign full_dplx_o        = cfg.fdx;
  assign link_pulse_tx_en_o = cfg.link_on;

  // indicators: 1 = released, 0 = pulled low
  assign led_port_n_o = ~cfg.port_tp | blink_phase;
  assign led_act_n_o  = ~act_on;
  assign led_link_n_o = ~(link_det_i & cfg.link_on);
  assign led_fdx_n_o  = ~cfg.fdx;
endmodule

// File: rtl/strap_port_ctrl_chk.sv
module strap_port_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic force_aui_i,
  input logic force_tp_i,
  input logic link_en_i,
  input logic strap_a_i,
  input logic link_det_i,
  input logic tx_act_i,
  input logic rx_act_i,
  input logic port_tp_o,
  input logic sqe_test_en_o,
  input logic loopback_en_o,
  input logic jabber_en_o,
  input logic auto_dplx_en_o,
  input logic full_dplx_o,
  input logic link_pulse_tx_en_o,
  input logic led_port_n_o,
  input logic led_act_n_o,
  input logic led_link_n_o,
  input logic led_fdx_n_o
);
  logic past_ok;
  logic auto_lnk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assign auto_lnk = ~force_aui_i & ~force_tp_i & link_en_i;

  a_r1_forced_tp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_tp_i && !force_aui_i) |-> port_tp_o);

  a_r1_forced_aui: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_aui_i |-> (!port_tp_o && !full_dplx_o));

  a_r2_auto_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && auto_lnk && $past(auto_lnk)) |-> (port_tp_o == $past(link_det_i)));

  a_r3_link_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!link_en_i && !full_dplx_o) |-> (!link_pulse_tx_en_o && led_link_n_o));

  a_r4_fdx_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_dplx_o |-> (port_tp_o && link_pulse_tx_en_o && !led_fdx_n_o && strap_a_i));

  a_r5_pin_a_ctx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sqe_test_en_o |-> (port_tp_o && link_en_i)) and
    (loopback_en_o |-> (!port_tp_o && !link_en_i)));

  a_r6_pin_b_ctx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_dplx_en_o |-> (port_tp_o && link_en_i && jabber_en_o));

  a_r7_act_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_act_i || rx_act_i) |=> !led_act_n_o);

  a_r8_aui_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_tp_o |-> led_port_n_o);
endmodule

bind strap_port_ctrl strap_port_ctrl_chk u_chk (
  .clk_i              (clk_i),
  .rst_ni             (rst_ni),
  .force_aui_i        (force_aui_i),
  .force_tp_i         (force_tp_i),
  .link_en_i          (link_en_i),
  .strap_a_i          (strap_a_i),
  .link_det_i         (link_det_i),
  .tx_act_i           (tx_act_i),
  .rx_act_i           (rx_act_i),
  .port_tp_o          (port_tp_o),
  .sqe_test_en_o      (sqe_test_en_o),
  .loopback_en_o      (loopback_en_o),
  .jabber_en_o        (jabber_en_o),
  .auto_dplx_en_o     (auto_dplx_en_o),
  .full_dplx_o        (full_dplx_o),
  .link_pulse_tx_en_o (link_pulse_tx_en_o),
  .led_port_n_o       (led_port_n_o),
  .led_act_n_o        (led_act_n_o),
  .led_link_n_o       (led_link_n_o),
  .led_fdx_n_o        (led_fdx_n_o)
);

// File: tb/strap_port_ctrl_bench.sv
`timescale 1ns/1ps
module strap_port_ctrl_bench;
  localparam int unsigned DIV = 4;
  localparam int unsigned STR = 5;
  localparam int unsigned BLK = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic f_aui = 0, f_tp = 0, l_en = 0, s_a = 0, s_b = 0, l_det = 0, p_rev = 0, tx = 0, rx = 0;
  logic port_tp, sqe, lpbk, jab, adplx, fdx, lpt, ledp, leda, ledl, ledf;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    string       tag;
    logic [9:0]  exp;
  } sb_item_t;
  sb_item_t sb_q[$];

  always #10 clk = ~clk;

  strap_port_ctrl #(
    .TICK_DIV(DIV), .STRETCH_TICKS(STR), .BLINK_TICKS(BLK)
  ) u_strap_port_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .force_aui_i(f_aui), .force_tp_i(f_tp), .link_en_i(l_en),
    .strap_a_i(s_a), .strap_b_i(s_b), .link_det_i(l_det),
    .pol_rev_i(p_rev), .tx_act_i(tx), .rx_act_i(rx),
    .port_tp_o(port_tp), .sqe_test_en_o(sqe), .loopback_en_o(lpbk),
    .jabber_en_o(jab), .auto_dplx_en_o(adplx), .full_dplx_o(fdx),
    .link_pulse_tx_en_o(lpt), .led_port_n_o(ledp), .led_act_n_o(leda),
    .led_link_n_o(ledl), .led_fdx_n_o(ledf)
  );

  function automatic logic [9:0] obs();
    return {port_tp, sqe, lpbk, jab, adplx, fdx, lpt, ledp, ledl, ledf};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: compare one expected item per falling edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      sb_item_t it;
      it = sb_q.pop_front();
      n_chk++;
      if (obs() !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %b expected %b", it.tag, obs(), it.exp);
      end
    end
  end

  // driver: set straps, let one edge pass, queue the expected outputs
  // exp order: port_tp sqe lpbk jab adplx fdx lpt led_port_n led_link_n led_fdx_n
  task automatic apply(input logic aui, input logic tp, input logic len,
                       input logic a, input logic b, input logic ld,
                       input string tag, input logic [9:0] exp);
    sb_item_t it;
    @(negedge clk); #1;
    f_aui = aui; f_tp = tp; l_en = len; s_a = a; s_b = b; l_det = ld;
    @(posedge clk);
    it.tag = tag; it.exp = exp;
    sb_q.push_back(it);
  endtask

  task automatic drain();
    wait (sb_q.size() == 0);
    @(negedge clk);
  endtask

  task automatic act_pulse(input bit use_rx);
    @(negedge clk); #1;
    if (use_rx) rx = 1; else tx = 1;
    @(negedge clk); #1;
    tx = 0; rx = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int lowc;
    int t0;
    int t1;
    int t2;
    int cyc;
    logic prev;
    repeat (3) @(negedge clk);
    chk(leda === 1'b1, "R7 reset act led", leda, 1);
    #1 rst_n = 1;
    @(negedge clk);
    // reset state, straps all zero: R3 AUI with loopback on
    chk(obs() === 10'b0010000111, "R3 reset state", obs(), 10'b0010000111);
    chk(leda === 1'b1, "R7 idle act led", leda, 1);

    apply(0,1,1,1,1,0, "R1 R5 forced TP sqe on",       10'b1101001011);
    apply(0,1,1,0,0,1, "R5 R6 R9 TP adplx link",       10'b1001101001);
    apply(1,0,0,0,0,1, "R1 R3 R5 AUI loopback",        10'b0010000111);
    apply(1,0,0,1,1,0, "R5 R6 AUI jabber",             10'b0001000111);
    apply(1,1,1,1,0,1, "R1 invalid code is AUI",       10'b0001001101);
    apply(0,0,0,1,0,1, "R4 R9 full duplex forced",     10'b1001011000);
    apply(0,0,0,0,1,1, "R3 auto w/o link enable",      10'b0011000111);
    apply(0,0,1,1,1,1, "R2 auto picks TP on link",     10'b1101001001);
    drain();

    // R2 registered: drop link, check before and after the next edge
    #1 l_det = 0;
    #2;
    chk(port_tp === 1'b1, "R2 port holds before edge", port_tp, 1);
    @(negedge clk);
    chk(port_tp === 1'b0, "R2 port AUI after edge", port_tp, 0);
    apply(0,0,1,1,1,0, "R2 auto AUI without link",     10'b0001001111);
    drain();

    // R7 single pulse: exact stretch length
    act_pulse(0);
    lowc = (leda === 1'b0) ? 1 : 0;
    repeat (40) begin
      @(negedge clk);
      if (leda === 1'b0) lowc++;
    end
    chk(lowc == STR*DIV, "R7 stretch length", lowc, STR*DIV);

    // R7 retrigger mid-window
    act_pulse(1);
    repeat (8) @(negedge clk);
    chk(leda === 1'b0, "R7 still low mid window", leda, 0);
    act_pulse(0);
    lowc = (leda === 1'b0) ? 1 : 0;
    repeat (40) begin
      @(negedge clk);
      if (leda === 1'b0) lowc++;
    end
    chk(lowc == STR*DIV, "R7 retrigger restarts window", lowc, STR*DIV);

    // R8 blink on reversed polarity, TP forced
    @(negedge clk); #1;
    f_aui = 0; f_tp = 1; l_en = 1; p_rev = 1;
    #1;
    chk(ledp === 1'b0, "R8 blink starts low", ledp, 0);
    t0 = -1; t1 = -1; t2 = -1; cyc = 0; prev = ledp;
    repeat (60) begin
      @(negedge clk);
      cyc++;
      if (ledp !== prev) begin
        if (t0 < 0) t0 = cyc;
        else if (t1 < 0) t1 = cyc;
        else if (t2 < 0) t2 = cyc;
      end
      prev = ledp;
    end
    chk((t1 - t0) == BLK*DIV, "R8 blink half period a", t1 - t0, BLK*DIV);
    chk((t2 - t1) == BLK*DIV, "R8 blink half period b", t2 - t1, BLK*DIV);
    @(negedge clk); #1 p_rev = 0;
    @(negedge clk);
    chk(ledp === 1'b0, "R8 steady low on TP", ledp, 0);
    #1 f_aui = 1; f_tp = 0; p_rev = 1;
    repeat (20) begin
      @(negedge clk);
      if (ledp !== 1'b1) begin
        n_chk++; n_fail++;
        $display("FAIL R8 AUI released: actual %0d expected 1", ledp);
      end
    end
    chk(ledp === 1'b1, "R8 AUI released", ledp, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule